// File: doc/BRIEF.md
# Buffer-to-Constant-File Copy Engine

This block takes one 64-bit shader load instruction, together with a constant-file start address and two resolved source operands. It checks that the word belongs to the constant-load instruction class and then sorts it into one of three cases. The bulk-copy form is executed here. The ordinary single-register load is passed on with a pulse. Every other variant is reported as illegal.

A bulk copy moves between 1 and 256 four-component vectors from a uniform buffer into the constant file. It issues one read request per vector on a simple request/response port and writes each returned 128-bit vector into the constant file. Vectors are handled in ascending order, so the result is the same as a run of single-vector loads, each followed by a store. Both the source offset and the destination must be aligned to four vectors. A transfer that breaks this rule is refused with an error pulse and makes no memory traffic.

Top module: `ubo_const_copier`

## Requirements
- R1: An instruction is taken only when `instValid` is high, `busy` is low and `instWord[19:14]` equals 6'b011110. Any other value of that field is ignored: no pulse follows, `busy` stays low and no request is made.
- R2: For an accepted word, `instWord[53:52]` selects the action. 2'b11 starts a bulk copy. 2'b10 raises `plainLoad` for exactly one cycle, in the cycle after acceptance. 2'b00 and 2'b01 raise `illegal` for one cycle in that same cycle.
- R3: A bulk copy moves `instWord[39:32]` + 1 vectors, which covers the full range from 1 to 256.
- R4: Vector i is requested with `memReqIdx` = `srcIdx` and `memReqOff` = `srcOff` + 16*i bytes, for i rising from 0. A request lasts one cycle, and the next request is issued only after the response to the previous one has arrived.
- R5: Each response is written in the cycle in which `memRspValid` is high. The data is `memRspData`, and the address is `cfWrAddr` = `baseAddr` + 4*i components, modulo 2^CF_AW.
- R6: The alignment rule is `srcOff[5:0]` == 0 and `baseAddr[3:0]` == 0. A bulk word that breaks it raises `alignErr` for one cycle, in the cycle after acceptance, with no request, no write and `busy` left low.
- R7: A bulk or plain word is reported through `illegal` instead, and starts nothing, when either bit of `srcHalf` (the half-precision flags of source 0 and source 1) is set.
- R8: `busy` is high from the cycle after a bulk word is accepted through the cycle of the final write. `done` pulses for one cycle immediately after that write. Instructions presented while `busy` is high are ignored.
- R9: While reset is active and right after it, `busy`, `done`, `alignErr`, `illegal`, `plainLoad`, `memReqValid` and `cfWrEn` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction offered |
| instWord | input | 64 | Instruction word |
| baseAddr | input | CF_AW | Constant-file start address, in components |
| srcIdx | input | 32 | Buffer index operand |
| srcOff | input | 32 | Buffer byte offset operand |
| srcHalf | input | 2 | Half-precision flags of the two sources |
| memReqValid | output | 1 | Read request strobe |
| memReqIdx | output | 32 | Buffer index of the request |
| memReqOff | output | 32 | Byte offset of the request |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 128 | Returned vector |
| cfWrEn | output | 1 | Constant-file write strobe |
| cfWrAddr | output | CF_AW | Constant-file write address, in components |
| cfWrData | output | 128 | Constant-file write data |
| busy | output | 1 | Bulk copy in progress |
| done | output | 1 | Bulk copy finished |
| alignErr | output | 1 | Misaligned bulk copy refused |
| illegal | output | 1 | Variant not allowed, or half-precision source |
| plainLoad | output | 1 | Ordinary load recognised |

## Verification
The `done` pulse of one copy and the acceptance of the next instruction fall in the same cycle, because `busy` drops as `done` rises. The bench provokes this by holding a second bulk word valid from the middle of a running copy until the `done` cycle has passed. It then judges two things: none of the second copy's requests or writes appear before the first copy's `done`, and the second copy starts exactly once, with its own addresses and data. Response latency is varied so that the final write and the following request land in different cycle patterns.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int CLS_LO = 14;
  localparam int CLS_HI = 19;
  localparam logic [5:0] CLS_PAT = 6'b011110;
  localparam int VAR_LO = 52;
  localparam int VAR_HI = 53;
  localparam logic [1:0] VAR_BULK = 2'b11;
  localparam logic [1:0] VAR_PLAIN = 2'b10;
  localparam int CNT_LO = 32;
  localparam int VEC_W = 128;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} ccpState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } ccpStrobe_t;
endpackage

// File: rtl/ccp_datapath.sv
module ccp_datapath
  import ccp_pkg::*;
#(
  parameter int CF_AW = 12,
  parameter int CNT_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccpStrobe_t        stb,
  input  logic [63:0]       instWord,
  input  logic [CF_AW-1:0]  baseAddr,
  input  logic [DATA_W-1:0] srcIdx,
  input  logic [DATA_W-1:0] srcOff,
  output logic              isClass,
  output logic              isBulk,
  output logic              isPlain,
  output logic              alignOk,
  output logic              lastVec,
  output logic [DATA_W-1:0] memReqIdx,
  output logic [DATA_W-1:0] memReqOff,
  output logic [CF_AW-1:0]  cfWrAddr
);
  localparam int VEC_BYTES_LG = $clog2(VEC_W / 8);
  localparam int ALIGN_BYTES_LG = VEC_BYTES_LG + 2;
  localparam int COMP_LG = 2;
  localparam int ALIGN_COMP_LG = COMP_LG + 2;

  logic [CF_AW-1:0]  baseR;
  logic [DATA_W-1:0] offR;
  logic [DATA_W-1:0] idxR;
  logic [CNT_W-1:0]  cntR;
  logic [CNT_W-1:0]  vecR;
  logic              unusedInst;

  assign unusedInst = ^{instWord[63:VAR_HI+1], instWord[VAR_LO-1:CNT_LO+CNT_W],
                        instWord[CNT_LO-1:CLS_HI+1], instWord[CLS_LO-1:0]};

  assign isClass = instWord[CLS_HI:CLS_LO] == CLS_PAT;
  assign isBulk  = instWord[VAR_HI:VAR_LO] == VAR_BULK;
  assign isPlain = instWord[VAR_HI:VAR_LO] == VAR_PLAIN;
  assign alignOk = (srcOff[ALIGN_BYTES_LG-1:0] == '0) && (baseAddr[ALIGN_COMP_LG-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR <= '0;
      offR  <= '0;
      idxR  <= '0;
      cntR  <= '0;
      vecR  <= '0;
    end else if (stb.load) begin
      baseR <= baseAddr;
      offR  <= srcOff;
      idxR  <= srcIdx;
      cntR  <= instWord[CNT_LO +: CNT_W];
      vecR  <= '0;
    end else if (stb.advance) begin
      vecR <= vecR + 1'b1;
    end
  end

  assign lastVec   = vecR == cntR;
  assign memReqIdx = idxR;
  assign memReqOff = offR + (DATA_W'(vecR) << VEC_BYTES_LG);
  assign cfWrAddr  = baseR + (CF_AW'(vecR) << COMP_LG);

  // R5: destination steps by one vector of components
  p_wr_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> cfWrAddr == $past(cfWrAddr) + CF_AW'(4));
  // R4: source offset steps by one vector of bytes
  p_req_off_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> memReqOff == $past(memReqOff) + DATA_W'(16));
endmodule

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
  import ccp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [1:0] srcHalf,
  input  logic       isClass,
  input  logic       isBulk,
  input  logic       isPlain,
  input  logic       alignOk,
  input  logic       lastVec,
  input  logic       memRspValid,
  output ccpStrobe_t stb,
  output logic       memReqValid,
  output logic       cfWrEn,
  output logic       busy,
  output logic       done,
  output logic       alignErr,
  output logic       illegal,
  output logic       plainLoad
);
  ccpState_e state, stateNxt;
  logic accept, anyHalf, startBulk, rspHit;

  assign anyHalf   = |srcHalf;
  assign accept    = instValid && (state == ST_IDLE) && isClass;
  assign startBulk = accept && isBulk && !anyHalf && alignOk;
  assign rspHit    = (state == ST_WAIT) && memRspValid;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (startBulk) stateNxt = ST_REQ;
      ST_REQ:  stateNxt = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNxt = lastVec ? ST_IDLE : ST_REQ;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      alignErr  <= 1'b0;
      illegal   <= 1'b0;
      plainLoad <= 1'b0;
    end else begin
      state     <= stateNxt;
      done      <= rspHit && lastVec;
      alignErr  <= accept && isBulk && !anyHalf && !alignOk;
      illegal   <= accept && (anyHalf || !(isBulk || isPlain));
      plainLoad <= accept && isPlain && !anyHalf;
    end
  end

  assign stb.load    = startBulk;
  assign stb.advance = rspHit && !lastVec;
  assign memReqValid = state == ST_REQ;
  assign cfWrEn      = rspHit;
  assign busy        = state != ST_IDLE;

  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  p_write_while_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfWrEn |-> busy);
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(cfWrEn) && !busy));
  p_results_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, alignErr, illegal, plainLoad}));
  p_refused_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (alignErr || illegal) |-> !busy);
endmodule

// File: rtl/ubo_const_copier.sv
module ubo_const_copier
  import ccp_pkg::*;
#(
  parameter int CF_AW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [63:0]      instWord,
  input  logic [CF_AW-1:0] baseAddr,
  input  logic [31:0]      srcIdx,
  input  logic [31:0]      srcOff,
  input  logic [1:0]       srcHalf,
  output logic             memReqValid,
  output logic [31:0]      memReqIdx,
  output logic [31:0]      memReqOff,
  input  logic             memRspValid,
  input  logic [127:0]     memRspData,
  output logic             cfWrEn,
  output logic [CF_AW-1:0] cfWrAddr,
  output logic [127:0]     cfWrData,
  output logic             busy,
  output logic             done,
  output logic             alignErr,
  output logic             illegal,
  output logic             plainLoad
);
  ccpStrobe_t stb;
  logic isClass, isBulk, isPlain, alignOk, lastVec;

  ccp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .srcHalf(srcHalf),
    .isClass(isClass), .isBulk(isBulk), .isPlain(isPlain), .alignOk(alignOk),
    .lastVec(lastVec), .memRspValid(memRspValid), .stb(stb),
    .memReqValid(memReqValid), .cfWrEn(cfWrEn), .busy(busy), .done(done),
    .alignErr(alignErr), .illegal(illegal), .plainLoad(plainLoad)
  );

  ccp_datapath #(.CF_AW(CF_AW), .CNT_W(8), .DATA_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .instWord(instWord), .baseAddr(baseAddr),
    .srcIdx(srcIdx), .srcOff(srcOff), .isClass(isClass), .isBulk(isBulk),
    .isPlain(isPlain), .alignOk(alignOk), .lastVec(lastVec),
    .memReqIdx(memReqIdx), .memReqOff(memReqOff), .cfWrAddr(cfWrAddr)
  );

  assign cfWrData = memRspData;
endmodule

// File: tb/ubo_const_copier_bench.sv
`timescale 1ns/1ps
module ubo_const_copier_bench;
  localparam int CF_AW = 12;
  localparam int NV = 6;
  localparam int tCnt [NV]  = '{1, 4, 7, 3, 256, 16};
  localparam int tBase [NV] = '{0, 16, 256, 4080, 1024, 32};
  localparam int tOff [NV]  = '{0, 64, 1088, 64, 4096, 128};
  localparam int tIdx [NV]  = '{3, 1, 9, 2, 0, 5};
  localparam int tLat [NV]  = '{0, 1, 2, 0, 0, 3};

  logic clk = 0, rstN = 0, instValid = 0, memRspValid = 0;
  logic [63:0] instWord = '0;
  logic [CF_AW-1:0] baseAddr = '0;
  logic [31:0] srcIdx = '0, srcOff = '0;
  logic [1:0] srcHalf = '0;
  logic [127:0] memRspData = '0;
  logic memReqValid, cfWrEn, busy, done, alignErr, illegal, plainLoad;
  logic [31:0] memReqIdx, memReqOff;
  logic [CF_AW-1:0] cfWrAddr;
  logic [127:0] cfWrData;

  int checks = 0, fails = 0, cyc = 0, lat = 0;
  int reqCnt = 0, wrCnt = 0, totalReq = 0, totalWr = 0, lastWr = -10, outst = 0;
  bit armed = 0, jobDone = 0, pendValid = 0;
  int eBase, eOff, eIdx, eN, pBase, pOff, pIdx, pN;

  always #2 clk = ~clk;

  ubo_const_copier #(.CF_AW(CF_AW)) u_ubo_const_copier (.*);

  function automatic logic [127:0] memWord(input logic [31:0] idx, input logic [31:0] off);
    return {idx ^ 32'hA5A5_0000, off, ~off, off * 32'd3 + idx};
  endfunction

  function automatic logic [63:0] mkInst(input logic [1:0] vsel, input int cntm1, input logic [5:0] cls);
    logic [63:0] w = '0;
    w[19:14] = cls;
    w[53:52] = vsel;
    w[39:32] = cntm1[7:0];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        automatic logic [31:0] ri = memReqIdx, ro = memReqOff;
        repeat (lat) @(posedge clk);
        @(posedge clk); #1;
        memRspValid = 1; memRspData = memWord(ri, ro);
        @(posedge clk); #1;
        memRspValid = 0;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    cyc++;
    if (rstN && memReqValid) begin
      totalReq++;
      chk(armed && outst == 0, "R4 outstanding", 128'(outst), 0);
      chk(memReqOff == 32'(eOff + 16 * reqCnt) && memReqIdx == 32'(eIdx), "R4 request",
          {memReqIdx, memReqOff}, {32'(eIdx), 32'(eOff + 16 * reqCnt)});
      outst = 1; reqCnt++;
    end
    if (rstN && cfWrEn) begin
      totalWr++;
      chk(armed && busy, "R8 busy at write", 128'(busy), 1);
      chk(cfWrAddr == CF_AW'(eBase + 4 * wrCnt), "R5 address", 128'(cfWrAddr), 128'(CF_AW'(eBase + 4 * wrCnt)));
      chk(cfWrData == memWord(32'(eIdx), 32'(eOff + 16 * wrCnt)), "R5 data", cfWrData,
          memWord(32'(eIdx), 32'(eOff + 16 * wrCnt)));
      outst = 0; wrCnt++; lastWr = cyc;
    end
    if (rstN && done) begin
      chk(cyc == lastWr + 1 && !busy, "R8 done timing", 128'(cyc - lastWr), 1);
      chk(wrCnt == eN && reqCnt == eN, "R3 vector count", 128'(wrCnt), 128'(eN));
      armed = 0; jobDone = 1;
      if (pendValid) begin
        eBase = pBase; eOff = pOff; eIdx = pIdx; eN = pN;
        reqCnt = 0; wrCnt = 0; armed = 1; pendValid = 0;
      end
    end
  end

  task automatic arm(input int b, input int o, input int i, input int n);
    eBase = b; eOff = o; eIdx = i; eN = n; reqCnt = 0; wrCnt = 0; armed = 1; jobDone = 0;
  endtask

  task automatic issue(input logic [63:0] w, input int b, input int o, input int i, input logic [1:0] h);
    @(negedge clk);
    instWord = w; baseAddr = CF_AW'(b); srcOff = 32'(o); srcIdx = 32'(i); srcHalf = h; instValid = 1;
    @(negedge clk);
    instValid = 0;
  endtask

  task automatic waitJob(input string req);
    int t = 0;
    while (!jobDone && t < 5000) begin @(negedge clk); t++; end
    chk(jobDone, req, 128'(jobDone), 1);
  endtask

  task automatic refused(input logic [63:0] w, input int b, input int o, input logic [1:0] h,
                         input logic [3:0] expPulses, input string req);
    int r0;
    r0 = totalReq;
    issue(w, b, o, 7, h);
    chk({alignErr, illegal, plainLoad, busy} == expPulses, req,
        128'({alignErr, illegal, plainLoad, busy}), 128'(expPulses));
    repeat (4) @(negedge clk);
    chk(totalReq == r0 && !busy, {req, " no traffic"}, 128'(totalReq - r0), 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, alignErr, illegal, plainLoad, memReqValid, cfWrEn} == 0, "R9 in reset",
        128'({busy, done, alignErr, illegal, plainLoad, memReqValid, cfWrEn}), 0);
    rstN = 1;
    @(negedge clk);
    chk({busy, done, alignErr, illegal, plainLoad, memReqValid, cfWrEn} == 0, "R9 after reset",
        128'({busy, done, alignErr, illegal, plainLoad, memReqValid, cfWrEn}), 0);

    for (int k = 0; k < NV; k++) begin
      lat = tLat[k];
      arm(tBase[k], tOff[k], tIdx[k], tCnt[k]);
      issue(mkInst(2'b11, tCnt[k] - 1, 6'b011110), tBase[k], tOff[k], tIdx[k], 2'b00);
      chk(busy, "R8 busy after accept", 128'(busy), 1);
      waitJob("R3 copy completes");
    end

    lat = 0;
    // R2 plain load, R2 other variants, R1 class mismatch, R7 half sources, R6 alignment
    refused(mkInst(2'b10, 0, 6'b011110), 0, 0, 2'b00, 4'b0010, "R2 plain");
    refused(mkInst(2'b01, 3, 6'b011110), 0, 0, 2'b00, 4'b0100, "R2 variant01");
    refused(mkInst(2'b00, 3, 6'b011110), 0, 0, 2'b00, 4'b0100, "R2 variant00");
    refused(mkInst(2'b11, 3, 6'b011111), 0, 0, 2'b00, 4'b0000, "R1 class mismatch");
    refused(mkInst(2'b11, 3, 6'b011110), 0, 0, 2'b01, 4'b0100, "R7 half src0");
    refused(mkInst(2'b11, 3, 6'b011110), 0, 0, 2'b10, 4'b0100, "R7 half src1");
    refused(mkInst(2'b11, 3, 6'b011110), 0, 32, 2'b00, 4'b1000, "R6 offset misaligned");
    refused(mkInst(2'b11, 3, 6'b011110), 4, 0, 2'b00, 4'b1000, "R6 base misaligned");

    // R8: second word held through busy; accepted in the done cycle only
    lat = 1;
    arm(64, 192, 4, 3);
    pBase = 512; pOff = 320; pIdx = 6; pN = 2; pendValid = 1;
    issue(mkInst(2'b11, 2, 6'b011110), 64, 192, 4, 2'b00);
    instWord = mkInst(2'b11, 1, 6'b011110); baseAddr = CF_AW'(512); srcOff = 320; srcIdx = 6;
    instValid = 1;
    while (!done) @(negedge clk);
    @(negedge clk);
    instValid = 0;
    chk(busy && armed, "R8 accepted at done", 128'(busy), 1);
    jobDone = 0;
    waitJob("R8 second copy completes");
    repeat (5) @(negedge clk);
    chk(!busy && totalWr == totalReq, "R8 single start", 128'(busy), 0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule